// File: doc/BRIEF.md
# Phase-Locked Loop Digital Lock Indicator with Output Mute

This block watches the up and down correction pulses that a phase-frequency detector sends to its charge pump. It decides whether the loop has settled. The pulses are sampled on a fast local clock. On every comparison cycle the block measures how long each pulse stayed high, in ticks of that clock, and uses the wider of the two as the phase error for that cycle. A cycle ends when both pulses have returned low after some activity.

The indicator uses hysteresis. It rises only after a run of consecutive cycles whose error is below a tight acquire limit. The length of that run is picked by a mode input. Once the indicator is high, it falls only when a single cycle exceeds a looser loss limit. A companion output enables the RF driver. When muting is requested, that output stays off until the indicator is high. A power-down input clears all measurement and lock state and disables the output.

Top module: `ldet_lock_detector`

## Requirements
- R1: After reset the lock flag `locked_o` is 0, and with muting enabled `rf_en_o` is 0.
- R2: The error of a cycle is the larger of two counts: the number of sampled clock edges at which `up_i` was high, and the number at which `dn_i` was high. A cycle closes on the first edge at which both inputs are low after at least one edge with either one high.
- R3: With `mode_five_i` = 0, the flag rises after 3 consecutive closed cycles whose error is below ACQ_TICKS (default 3 ticks).
- R4: With `mode_five_i` = 1, 5 such consecutive cycles are required.
- R5: While unlocked, a closed cycle with error at or above ACQ_TICKS sets the run of good cycles back to zero.
- R6: While locked, cycles with error at or below LOSE_TICKS (default 5 ticks) leave the flag high, including errors between the two limits.
- R7: While locked, one closed cycle with error above LOSE_TICKS drops the flag.
- R8: The flag changes only at the edge where a cycle closes, and the new value is visible immediately after that edge.
- R9: With `mute_en_i` = 1, `rf_en_o` equals the lock flag (when not powered down). With `mute_en_i` = 0, `rf_en_o` is 1 whenever not powered down.
- R10: While `pwr_dn_i` = 1, `rf_en_o` is 0. The edge that samples power-down clears the flag, the run of good cycles and the pulse-width counts.
- R11: Pulse-width counts saturate at 2^CNT_W-1 (255 by default) and do not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Up correction pulse, synchronous to clk_i |
| dn_i | input | 1 | Down correction pulse, synchronous to clk_i |
| mode_five_i | input | 1 | 0: three good cycles needed, 1: five |
| mute_en_i | input | 1 | Hold the RF enable off until lock |
| pwr_dn_i | input | 1 | Power-down, clears lock-detect state |
| locked_o | output | 1 | Active-high digital lock flag |
| rf_en_o | output | 1 | RF output-stage enable |

## Verification
The checker assumes that the correction pulses are already synchronous to the sample clock. It also assumes that the mode input is only meaningful at the edge where a cycle closes. The bench therefore changes every input on the falling clock edge and never on the sampling edge.

The stimulus covers several cases:
- pulses wide enough to saturate the counters;
- pulses on one line only, with the other held low;
- edges where no pulse is present at all, so no cycle closes;
- power-down asserted in the middle of an acquisition run.

Under these conditions the flag may only move at a cycle close or during power-down, and the checker's rules hold.

// File: rtl/ldet_pkg.sv
package ldet_pkg;

  typedef enum logic {
    ST_ACQUIRE = 1'b0,
    ST_LOCKED  = 1'b1
  } ldet_state_e;

  // Index of the two correction lines inside the pulse-meter lane vector.
  localparam int unsigned LANE_UP = 0;
  localparam int unsigned LANE_DN = 1;
  localparam int unsigned LANES   = 2;

  // Larger of two widths.
  function automatic int unsigned wider_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Required run length for the chosen mode.
  function automatic int unsigned run_needed(input logic five, input int unsigned short_run,
                                             input int unsigned long_run);
    return five ? long_run : short_run;
  endfunction

  // RF enable rule.
  function automatic logic rf_gate(input logic pd, input logic mute, input logic lk);
    return !pd && (!mute || lk);
  endfunction

endpackage

// File: rtl/ldet_pulse_meter.sv
module ldet_pulse_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             done_o,
  output logic [CNT_W-1:0] err_o
);
  import ldet_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [LANES-1:0] pulse;
  logic [CNT_W-1:0] width_q [LANES];
  logic             any_now;
  logic             any_q;

  assign pulse[LANE_UP] = up_i;
  assign pulse[LANE_DN] = dn_i;
  assign any_now = |pulse;
  assign done_o  = any_q & ~any_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     any_q <= 1'b0;
    else if (clr_i)  any_q <= 1'b0;
    else             any_q <= any_now;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              width_q[g] <= '0;
      else if (clr_i || done_o)                 width_q[g] <= '0;
      else if (pulse[g] && width_q[g] != CNT_MAX) width_q[g] <= width_q[g] + CNT_ONE;
    end
  end

  assign err_o = CNT_W'(wider_of(int'(width_q[LANE_UP]), int'(width_q[LANE_DN])));

endmodule

// File: rtl/ldet_lock_fsm.sv
module ldet_lock_fsm #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ACQ_TICKS  = 3,
  parameter int unsigned LOSE_TICKS = 5,
  parameter int unsigned RUN_SHORT  = 3,
  parameter int unsigned RUN_LONG   = 5,
  localparam int unsigned GOOD_W    = $clog2(RUN_LONG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  err_i,
  input  logic              mode_five_i,
  output logic              locked_o,
  output logic [GOOD_W-1:0] good_o
);
  import ldet_pkg::*;

  localparam logic [CNT_W-1:0]  ACQ_L  = CNT_W'(ACQ_TICKS);
  localparam logic [CNT_W-1:0]  LOSE_L = CNT_W'(LOSE_TICKS);
  localparam logic [GOOD_W-1:0] ONE_G  = GOOD_W'(1);

  ldet_state_e       state_q, state_d;
  logic [GOOD_W-1:0] good_q, good_d, need, good_inc;
  logic              err_fine, err_bad;

  assign need     = GOOD_W'(run_needed(mode_five_i, RUN_SHORT, RUN_LONG));
  assign good_inc = good_q + ONE_G;
  assign err_fine = err_i < ACQ_L;
  assign err_bad  = err_i > LOSE_L;

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    if (done_i) begin
      unique case (state_q)
        ST_ACQUIRE: begin
          if (!err_fine) begin
            good_d = '0;
          end else if (good_inc >= need) begin
            state_d = ST_LOCKED;
            good_d  = '0;
          end else begin
            good_d = good_inc;
          end
        end
        ST_LOCKED: begin
          if (err_bad) begin
            state_d = ST_ACQUIRE;
            good_d  = '0;
          end
        end
        default: begin
          state_d = ST_ACQUIRE;
          good_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQUIRE;
      good_q  <= '0;
    end else if (clr_i) begin
      state_q <= ST_ACQUIRE;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
    end
  end

  assign locked_o = (state_q == ST_LOCKED);
  assign good_o   = good_q;

endmodule

// File: rtl/ldet_lock_detector.sv
module ldet_lock_detector #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ACQ_TICKS  = 3,
  parameter int unsigned LOSE_TICKS = 5,
  parameter int unsigned RUN_SHORT  = 3,
  parameter int unsigned RUN_LONG   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic mode_five_i,
  input  logic mute_en_i,
  input  logic pwr_dn_i,
  output logic locked_o,
  output logic rf_en_o
);
  import ldet_pkg::*;

  localparam int unsigned GOOD_W = $clog2(RUN_LONG + 1);

  // Named internal events, used by the bound checker.
  logic              cycle_done;
  logic [CNT_W-1:0]  cycle_err;
  logic [GOOD_W-1:0] good_run;
  logic              lock_flag;

  ldet_pulse_meter #(.CNT_W(CNT_W)) meter_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwr_dn_i),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .done_o (cycle_done),
    .err_o  (cycle_err)
  );

  ldet_lock_fsm #(
    .CNT_W(CNT_W), .ACQ_TICKS(ACQ_TICKS), .LOSE_TICKS(LOSE_TICKS),
    .RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pwr_dn_i),
    .done_i      (cycle_done),
    .err_i       (cycle_err),
    .mode_five_i (mode_five_i),
    .locked_o    (lock_flag),
    .good_o      (good_run)
  );

  assign locked_o = lock_flag;
  assign rf_en_o  = rf_gate(pwr_dn_i, mute_en_i, lock_flag);

endmodule

// File: rtl/ldet_lock_checker.sv
module ldet_lock_checker #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ACQ_TICKS  = 3,
  parameter int unsigned LOSE_TICKS = 5,
  parameter int unsigned RUN_LONG   = 5,
  parameter int unsigned GOOD_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_dn_i,
  input logic              mute_en_i,
  input logic              cycle_done,
  input logic [CNT_W-1:0]  cycle_err,
  input logic [GOOD_W-1:0] good_run,
  input logic              locked_o,
  input logic              rf_en_o
);
  localparam logic [CNT_W-1:0]  ACQ_L  = CNT_W'(ACQ_TICKS);
  localparam logic [CNT_W-1:0]  LOSE_L = CNT_W'(LOSE_TICKS);
  localparam logic [GOOD_W-1:0] LONG_G = GOOD_W'(RUN_LONG);

  assert_pd_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !locked_o);
  assert_pd_rf_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> !rf_en_o);
  assert_mute_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_en_i && !locked_o) |-> !rf_en_o);
  assert_unmuted_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_en_i && !pwr_dn_i) |-> rf_en_o);
  assert_rise_at_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(cycle_done));
  assert_rise_good_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(cycle_err) < ACQ_L));
  assert_fall_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> ($past(pwr_dn_i) || ($past(cycle_done) && ($past(cycle_err) > LOSE_L))));
  assert_hold_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !pwr_dn_i && !(cycle_done && cycle_err > LOSE_L)) |=> locked_o);
  assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_run < LONG_G);

endmodule

bind ldet_lock_detector ldet_lock_checker #(
  .CNT_W(CNT_W), .ACQ_TICKS(ACQ_TICKS), .LOSE_TICKS(LOSE_TICKS),
  .RUN_LONG(RUN_LONG), .GOOD_W(GOOD_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_dn_i   (pwr_dn_i),
  .mute_en_i  (mute_en_i),
  .cycle_done (cycle_done),
  .cycle_err  (cycle_err),
  .good_run   (good_run),
  .locked_o   (locked_o),
  .rf_en_o    (rf_en_o)
);

// File: tb/ldet_lock_detector_tb.sv
`timescale 1ns/1ps
module ldet_lock_detector_tb_top;
  localparam int ACQ  = 3;
  localparam int LOSE = 5;
  localparam int WMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, mode5 = 1'b0, mute = 1'b1, pd = 1'b0;
  logic locked, rf_en;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ldet_lock_detector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .mode_five_i(mode5),
    .mute_en_i(mute), .pwr_dn_i(pd), .locked_o(locked), .rf_en_o(rf_en)
  );

  // Behavioural reference model
  int  m_uw = 0, m_dw = 0, m_good = 0;
  bit  m_prev = 0, m_lk = 0;

  always @(posedge clk) begin
    if (!rst_n || pd) begin
      m_uw = 0; m_dw = 0; m_good = 0; m_prev = 0; m_lk = 0;
    end else begin
      if (m_prev && !(up || dn)) begin
        int e;
        int need;
        e = (m_uw > m_dw) ? m_uw : m_dw;
        need = mode5 ? 5 : 3;
        if (!m_lk) begin
          if (e < ACQ) begin
            m_good++;
            if (m_good >= need) begin m_lk = 1; m_good = 0; end
          end else m_good = 0;
        end else if (e > LOSE) begin
          m_lk = 0; m_good = 0;
        end
        m_uw = 0; m_dw = 0;
      end else begin
        if (up && m_uw < WMAX) m_uw++;
        if (dn && m_dw < WMAX) m_dw++;
      end
      m_prev = up || dn;
    end
    #1;
    if (rst_n) begin
      bit exp_rf;
      exp_rf = !pd && (!mute || m_lk);
      n_chk++;
      if (locked !== m_lk || rf_en !== exp_rf) begin
        n_bad++;
        $display("FAIL %s model: locked=%b rf=%b expected locked=%b rf=%b",
                 cur_req, locked, rf_en, m_lk, exp_rf);
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s directed: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pcycle(input int uw, input int dw, input int gap);
    int len;
    len = ((uw > dw) ? uw : dw) + gap;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      up = (i < uw);
      dn = (i < dw);
    end
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) pcycle(1, 2, 2);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check(locked, 1'b0, "R1");
    check(rf_en, 1'b0, "R1");

    // R3: three good cycles in mode 0
    cur_req = "R3";
    goods(2);
    check(locked, 1'b0, "R3");
    goods(1);
    check(locked, 1'b1, "R3");
    check(rf_en, 1'b1, "R9");

    // R6: error between limits keeps lock
    cur_req = "R6";
    pcycle(4, 5, 2);
    check(locked, 1'b1, "R6");
    // R7: error above loss limit drops lock
    cur_req = "R7";
    pcycle(6, 1, 2);
    check(locked, 1'b0, "R7");
    check(rf_en, 1'b0, "R9");

    // R5: a bad cycle restarts the run
    cur_req = "R5";
    goods(2);
    pcycle(3, 0, 2);
    goods(2);
    check(locked, 1'b0, "R5");
    goods(1);
    check(locked, 1'b1, "R5");

    // R2: wider down pulse counts
    cur_req = "R2";
    pcycle(1, 6, 2);
    check(locked, 1'b0, "R2");

    // R4: five cycles in mode 1
    cur_req = "R4";
    mode5 = 1'b1;
    goods(4);
    check(locked, 1'b0, "R4");
    goods(1);
    check(locked, 1'b1, "R4");

    // R8: flag changes exactly at the close edge
    cur_req = "R8";
    for (int i = 0; i < 7; i++) begin @(negedge clk); up = 1'b1; end
    @(negedge clk); up = 1'b0;
    check(locked, 1'b1, "R8");
    @(posedge clk); #1;
    check(locked, 1'b0, "R8");
    mode5 = 1'b0;

    // R9: no mute
    cur_req = "R9";
    @(negedge clk); mute = 1'b0;
    #1 check(rf_en, 1'b1, "R9");
    @(negedge clk); mute = 1'b1;
    #1 check(rf_en, 1'b0, "R9");

    // R10: power-down mid acquisition clears the run
    cur_req = "R10";
    goods(2);
    @(negedge clk); pd = 1'b1;
    @(negedge clk); @(negedge clk); pd = 1'b0;
    goods(1);
    check(locked, 1'b0, "R10");
    goods(2);
    check(locked, 1'b1, "R10");
    @(negedge clk); pd = 1'b1; mute = 1'b0;
    #1 check(rf_en, 1'b0, "R10");
    @(negedge clk);
    check(locked, 1'b0, "R10");
    pd = 1'b0; mute = 1'b1;

    // R11: saturation, 258 ticks must not wrap to 2
    cur_req = "R11";
    goods(3);
    check(locked, 1'b1, "R11");
    pcycle(258, 0, 2);
    check(locked, 1'b0, "R11");

    // random stream compared against the model
    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      if (k % 97 == 0) mode5 = $urandom_range(1, 0) != 0;
      if (k % 53 == 0) mute = $urandom_range(1, 0) != 0;
      if (k % 331 == 5) begin
        @(negedge clk); pd = 1'b1; up = 1'b0; dn = 1'b0;
        @(negedge clk); pd = 1'b0;
      end
      if ($urandom_range(3, 0) == 0)
        pcycle($urandom_range(9, 0), $urandom_range(9, 0), $urandom_range(3, 1));
      else
        pcycle($urandom_range(2, 0), $urandom_range(2, 0), $urandom_range(3, 1));
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule